// File: doc/BRIEF.md
# Multi-Mode Operand Fetch Unit

This block sits between instruction decode and an accumulator datapath. Each request carries a mode code, an 8-bit address/literal field and a register index. The unit takes the request only while it is idle. It forms the effective address from the field, the register file, the program counter or a word fetched from memory. It then performs as many single-word memory reads as the mode needs, from none to two. It finishes with a one-cycle completion strobe that presents the operand and the effective address.

The register file and the program counter are wired in as flat buses and sampled when a request is taken. Register NREG-1 acts as the stack pointer. Memory is reached through a request port with a valid/ready handshake. A later return strobe carries the read data. Every address sum is 16 bits wide and wraps.

Top module: `opfetch_unit`

## Requirements
- R1: Mode code 0 (literal): operand and effective address both equal the zero-extended field, with no memory read.
- R2: Mode code 1 (absolute): the effective address is the zero-extended field, and one read returns the operand.
- R3: Mode code 2 (memory pointer): the word at the zero-extended field becomes the effective address, and a second read fetches the operand, for two reads in total.
- R4: Mode code 3 (register): the operand is register R, the effective address is 0, and no read is made.
- R5: Mode code 4 (register pointer): the effective address is register R, with exactly one read.
- R6: Mode code 5 (offset): the effective address is the field sign-extended from 8 bits plus register R, followed by one read.
- R7: Mode code 6 (PC-based): the effective address is the sign-extended field plus the program counter value at acceptance, followed by one read.
- R8: Mode code 7 (index then pointer): the pointer is read at field+R, that word is the effective address, and two reads are made.
- R9: Mode code 8 (pointer then index): the word at the field plus R is the effective address, and two reads are made.
- R10: Mode code 9 (stack top): the effective address is register NREG-1, the field is ignored, and one read is made.
- R11: All address arithmetic wraps modulo 2^16.
- R12: req_ready is high only when idle. No request is taken while reads are in flight. A pending memory request holds its address until it is accepted.
- R13: Each accepted request gives exactly one done pulse, in order. Mode codes 10-15 raise err with done, with operand and address 0 and no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| req_valid | input | 1 | request present |
| req_ready | output | 1 | unit idle, request taken at this edge |
| req_mode | input | 4 | addressing mode code |
| req_afield | input | 8 | address / literal field |
| req_reg | input | 3 | register index R |
| rf_flat | input | 128 | register file, register i at bits [16i+15:16i] |
| pc | input | 16 | current program counter |
| mem_valid | output | 1 | memory read request |
| mem_ready | input | 1 | memory accepts request |
| mem_addr | output | 16 | memory read address |
| mem_rvalid | input | 1 | read data returned |
| mem_rdata | input | 16 | read data |
| done | output | 1 | one-cycle completion strobe |
| err | output | 1 | unsupported mode, valid with done |
| operand | output | 16 | fetched operand |
| eff_addr | output | 16 | effective address |

## Verification
The completion strobe of one request and the acceptance of the next fall in the same cycle. When done rises, the unit is idle again, and a waiting request is taken at that edge. The bench drives requests back to back, including zero-read modes that complete every cycle. A scoreboard then judges every done against its expected operand, address, error flag and read count, in request order. The bench also holds a junk request asserted during multi-read modes while memory ready stalls at random. This shows that nothing is taken early.

// File: rtl/opfetch_pkg.sv
package opfetch_pkg;
   localparam int MODE_W = 4;
   typedef enum logic [MODE_W-1:0] {
      AM_LIT  = 4'd0,
      AM_ABS  = 4'd1,
      AM_MPTR = 4'd2,
      AM_REG  = 4'd3,
      AM_RPTR = 4'd4,
      AM_OFS  = 4'd5,
      AM_PCR  = 4'd6,
      AM_IXPT = 4'd7,
      AM_PTIX = 4'd8,
      AM_STK  = 4'd9
   } amode_e;
   typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} fstate_e;
endpackage

// File: rtl/opfetch_field_ext.sv
module opfetch_field_ext #(
   parameter int DW  = 16,
   parameter int AFW = 8
) (
   input  logic [AFW-1:0] afield,
   output logic [DW-1:0]  a_zext,
   output logic [DW-1:0]  a_sext
);
   generate
      if (AFW > DW) begin : g_bad
         $error("opfetch_field_ext: AFW must not exceed DW");
      end else if (AFW == DW) begin : g_same
         assign a_zext = afield;
         assign a_sext = afield;
      end else begin : g_ext
         localparam int PAD = DW - AFW;
         assign a_zext = {{PAD{1'b0}}, afield};
         assign a_sext = {{PAD{afield[AFW-1]}}, afield};
      end
   endgenerate
endmodule

// File: rtl/opfetch_reg_read.sv
module opfetch_reg_read #(
   parameter int DW   = 16,
   parameter int NREG = 8,
   localparam int RW  = $clog2(NREG)
) (
   input  logic [NREG*DW-1:0] rf_flat,
   input  logic [RW-1:0]      idx,
   output logic [DW-1:0]      rval,
   output logic [DW-1:0]      sp_val
);
   logic [DW-1:0] regs [NREG];
   generate
      if (NREG < 2) begin : g_bad
         $error("opfetch_reg_read: need at least two registers");
      end
      for (genvar i = 0; i < NREG; i++) begin : g_unpack
         assign regs[i] = rf_flat[i*DW +: DW];
      end
   endgenerate
   assign rval   = regs[idx];
   assign sp_val = regs[NREG-1];
endmodule

// File: rtl/opfetch_unit.sv
module opfetch_unit
   import opfetch_pkg::*;
#(
   parameter int DW   = 16,
   parameter int AFW  = 8,
   parameter int NREG = 8,
   localparam int RW  = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [MODE_W-1:0] req_mode,
   input  logic [AFW-1:0]    req_afield,
   input  logic [RW-1:0]     req_reg,
   input  logic [NREG*DW-1:0] rf_flat,
   input  logic [DW-1:0]     pc,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [DW-1:0]     mem_addr,
   input  logic              mem_rvalid,
   input  logic [DW-1:0]     mem_rdata,
   output logic              done,
   output logic              err,
   output logic [DW-1:0]     operand,
   output logic [DW-1:0]     eff_addr
);
   fstate_e       state_q;
   logic [DW-1:0] addr_q, idx_q, opnd_q, ea_q;
   logic          ptr_q, post_q, done_q, err_q;
   logic [DW-1:0] a_z, a_s, rval, sp_val;

   opfetch_field_ext #(.DW(DW), .AFW(AFW)) u_ext (
      .afield(req_afield), .a_zext(a_z), .a_sext(a_s));

   opfetch_reg_read #(.DW(DW), .NREG(NREG)) u_rf (
      .rf_flat(rf_flat), .idx(req_reg), .rval(rval), .sp_val(sp_val));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         idx_q   <= '0;
         opnd_q  <= '0;
         ea_q    <= '0;
         ptr_q   <= 1'b0;
         post_q  <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (req_valid) begin
               idx_q  <= rval;
               ptr_q  <= 1'b0;
               post_q <= 1'b0;
               case (req_mode)
                  AM_LIT: begin
                     done_q <= 1'b1; opnd_q <= a_z; ea_q <= a_z;
                  end
                  AM_REG: begin
                     done_q <= 1'b1; opnd_q <= rval; ea_q <= '0;
                  end
                  AM_ABS:  begin addr_q <= a_z;          state_q <= ST_ISSUE; end
                  AM_MPTR: begin addr_q <= a_z;          ptr_q <= 1'b1; state_q <= ST_ISSUE; end
                  AM_RPTR: begin addr_q <= rval;         state_q <= ST_ISSUE; end
                  AM_OFS:  begin addr_q <= a_s + rval;   state_q <= ST_ISSUE; end
                  AM_PCR:  begin addr_q <= a_s + pc;     state_q <= ST_ISSUE; end
                  AM_IXPT: begin addr_q <= a_z + rval;   ptr_q <= 1'b1; state_q <= ST_ISSUE; end
                  AM_PTIX: begin
                     addr_q <= a_z; ptr_q <= 1'b1; post_q <= 1'b1; state_q <= ST_ISSUE;
                  end
                  AM_STK:  begin addr_q <= sp_val;       state_q <= ST_ISSUE; end
                  default: begin
                     done_q <= 1'b1; err_q <= 1'b1; opnd_q <= '0; ea_q <= '0;
                  end
               endcase
            end
            ST_ISSUE: if (mem_ready) state_q <= ST_WAIT;
            ST_WAIT: if (mem_rvalid) begin
               if (ptr_q) begin
                  addr_q  <= post_q ? mem_rdata + idx_q : mem_rdata;
                  ptr_q   <= 1'b0;
                  state_q <= ST_ISSUE;
               end else begin
                  ea_q    <= addr_q;
                  opnd_q  <= mem_rdata;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign mem_valid = (state_q == ST_ISSUE);
   assign mem_addr  = addr_q;
   assign done      = done_q;
   assign err       = err_q;
   assign operand   = opnd_q;
   assign eff_addr  = ea_q;
endmodule

// File: rtl/opfetch_chk.sv
module opfetch_chk #(
   parameter int DW   = 16,
   parameter int AFW  = 8,
   parameter int NREG = 8,
   localparam int RW  = $clog2(NREG)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [3:0]        req_mode,
   input logic [AFW-1:0]    req_afield,
   input logic [RW-1:0]     req_reg,
   input logic [NREG*DW-1:0] rf_flat,
   input logic              mem_valid,
   input logic              mem_ready,
   input logic [DW-1:0]     mem_addr,
   input logic              done,
   input logic              err,
   input logic [DW-1:0]     operand
);
   logic take;
   logic [DW-1:0] fz;
   assign take = req_valid && req_ready;
   assign fz   = DW'(req_afield);

   p_lit_noread_r1: assert property (@(posedge clk) disable iff (!rst_n)
      take && req_mode == 4'd0 |=> done && !err && !mem_valid && operand == $past(fz));
   p_abs_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      take && req_mode == 4'd1 |=> mem_valid && mem_addr == $past(fz));
   p_reg_operand_r4: assert property (@(posedge clk) disable iff (!rst_n)
      take && req_mode == 4'd3 |=> done && !mem_valid && operand == $past(rf_flat[req_reg*DW +: DW]));
   p_stack_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      take && req_mode == 4'd9 |=> mem_valid && mem_addr == $past(rf_flat[(NREG-1)*DW +: DW]));
   p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr));
   p_busy_closed_r12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> !req_ready);
   p_err_with_done_r13: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);
   p_bad_mode_r13: assert property (@(posedge clk) disable iff (!rst_n)
      take && req_mode > 4'd9 |=> done && err && !mem_valid);
endmodule

bind opfetch_unit opfetch_chk #(.DW(DW), .AFW(AFW), .NREG(NREG)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_mode(req_mode), .req_afield(req_afield), .req_reg(req_reg),
   .rf_flat(rf_flat), .mem_valid(mem_valid), .mem_ready(mem_ready),
   .mem_addr(mem_addr), .done(done), .err(err), .operand(operand));

// File: tb/test_opfetch_unit.sv
`timescale 1ns/1ps
module test_opfetch_unit;
   localparam int DW = 16, AFW = 8, NREG = 8, RW = 3;

   typedef struct {
      logic [DW-1:0] ea;
      logic [DW-1:0] op;
      int            nr;
      bit            er;
      string         tag;
   } exp_t;

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, req_ready;
   logic [3:0] req_mode = 0;
   logic [AFW-1:0] req_afield = 0;
   logic [RW-1:0] req_reg = 0;
   logic [DW-1:0] rf [NREG];
   logic [NREG*DW-1:0] rf_flat;
   logic [DW-1:0] pc = 16'h0100;
   logic mem_valid, mem_ready = 0, mem_rvalid = 0;
   logic [DW-1:0] mem_addr, mem_rdata = 0;
   logic done, err;
   logic [DW-1:0] operand, eff_addr;

   exp_t sbq [$];
   int n_chk = 0, n_bad = 0, rd_cnt = 0, rd_mark = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #2 clk = ~clk;

   always_comb
      for (int i = 0; i < NREG; i++) rf_flat[i*DW +: DW] = rf[i];

   opfetch_unit #(.DW(DW), .AFW(AFW), .NREG(NREG)) i_opfetch_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_mode(req_mode), .req_afield(req_afield), .req_reg(req_reg),
      .rf_flat(rf_flat), .pc(pc), .mem_valid(mem_valid), .mem_ready(mem_ready),
      .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .done(done), .err(err), .operand(operand), .eff_addr(eff_addr));

   function automatic logic [DW-1:0] memf(logic [DW-1:0] a);
      return {a[7:0], a[15:8]} ^ 16'h1357;
   endfunction

   // memory model: read data returns one cycle after the handshake
   always @(posedge clk) begin
      mem_rvalid <= mem_valid && mem_ready;
      mem_rdata  <= memf(mem_addr);
      if (mem_valid && mem_ready) rd_cnt <= rd_cnt + 1;
   end

   always @(negedge clk) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_ready <= lfsr[0] | lfsr[3];
   end

   task automatic check(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   // monitor: pop and compare at each done
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sbq.size() == 0) begin
            check(0, "R13", "unexpected done", 16'd1, 16'd0);
         end else begin
            exp_t e;
            int nr;
            e = sbq.pop_front();
            nr = rd_cnt - rd_mark;
            rd_mark = rd_cnt;
            check(eff_addr == e.ea, e.tag, "eff_addr", eff_addr, e.ea);
            check(operand == e.op, e.tag, "operand", operand, e.op);
            check(err == e.er, e.tag, "err", DW'(err), DW'(e.er));
            check(nr == e.nr, e.tag, "read count", DW'(nr), DW'(e.nr));
         end
      end
   end

   function automatic exp_t model(logic [3:0] m, logic [7:0] a, logic [RW-1:0] r);
      exp_t e;
      logic [DW-1:0] az, as_, p;
      az = DW'(a);
      as_ = {{8{a[7]}}, a};
      e.er = 0; e.nr = 1; e.op = 0; e.ea = 0;
      case (m)
         0: begin e.tag = "R1"; e.nr = 0; e.ea = az; e.op = az; end
         1: begin e.tag = "R2"; e.ea = az; end
         2: begin e.tag = "R3"; e.nr = 2; e.ea = memf(az); end
         3: begin e.tag = "R4"; e.nr = 0; e.op = rf[r]; end
         4: begin e.tag = "R5"; e.ea = rf[r]; end
         5: begin e.tag = "R6"; e.ea = as_ + rf[r]; end
         6: begin e.tag = "R7"; e.ea = as_ + pc; end
         7: begin e.tag = "R8"; e.nr = 2; p = az + rf[r]; e.ea = memf(p); end
         8: begin e.tag = "R9"; e.nr = 2; e.ea = memf(az) + rf[r]; end
         9: begin e.tag = "R10"; e.ea = rf[NREG-1]; end
         default: begin e.tag = "R13"; e.nr = 0; e.er = 1; end
      endcase
      if (e.nr > 0) e.op = memf(e.ea);
      return e;
   endfunction

   // driver: push expectation, present request, optionally hold junk while busy
   task automatic drive(logic [3:0] m, logic [7:0] a, logic [RW-1:0] r, string tag_over, bit junk);
      exp_t e;
      bit acc;
      e = model(m, a, r);
      if (tag_over != "") e.tag = tag_over;
      sbq.push_back(e);
      req_mode = m; req_afield = a; req_reg = r; req_valid = 1;
      do begin
         acc = req_ready;
         @(negedge clk);
      end while (!acc);
      if (junk && e.nr > 0) begin
         req_mode = 4'd14; req_afield = 8'hFF; // R12: must not be taken while busy
         while (!done) @(negedge clk);
      end
      req_valid = 0;
   endtask

   initial begin
      for (int i = 0; i < NREG; i++) rf[i] = 16'h1000 * i[15:0] + 16'h0021;
      repeat (3) @(negedge clk);
      check(done == 0, "R13", "done after reset", DW'(done), 16'd0);
      check(req_ready == 1, "R12", "ready after reset", DW'(req_ready), 16'd1);
      check(mem_valid == 0, "R12", "mem_valid after reset", DW'(mem_valid), 16'd0);
      rst_n = 1;
      @(negedge clk);
      drive(0, 8'hF3, 0, "", 0);
      drive(1, 8'h40, 0, "", 1);
      drive(2, 8'h12, 0, "", 1);
      drive(3, 8'h00, 5, "", 0);
      drive(4, 8'h00, 2, "", 0);
      drive(5, 8'hFC, 3, "", 1);
      rf[3] = 16'h0002;
      drive(5, 8'hFC, 3, "R11", 0);     // 2 - 4 wraps to FFFE
      pc = 16'hFFF0;
      drive(6, 8'h7F, 0, "R11", 1);     // FFF0 + 7F wraps to 006F
      pc = 16'h0200;
      drive(6, 8'h80, 0, "", 0);
      drive(7, 8'h10, 1, "", 1);
      drive(8, 8'h10, 1, "", 1);
      drive(9, 8'hAA, 6, "", 0);
      drive(12, 8'h33, 2, "", 0);
      drive(15, 8'h01, 0, "", 1);
      // back-to-back zero-read requests: done and acceptance coincide
      drive(0, 8'h01, 0, "", 0);
      drive(3, 8'h00, 7, "", 0);
      drive(0, 8'h80, 0, "", 0);
      for (int k = 0; k < 60; k++) begin
         logic [15:0] v;
         v = lfsr;
         rf[k % NREG] = v ^ 16'h5A5A;
         pc = pc + 16'd3;
         drive(v[3:0], v[11:4], v[14:12], "", v[15]);
      end
      while (sbq.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      check(0, "R13", "watchdog expired", 16'd0, 16'd1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule